// File: doc/BRIEF.md
# SHA-1 Host Register Interface

This block puts a 32-bit word-addressed register file in front of a SHA-1 hashing engine. A host uses a chip select, a write enable, an 8-bit word address and 32-bit write data. It reads through a 32-bit read-data port. The host can read identification and version constants and the engine's status. It loads the sixteen words of a 512-bit message block, starts the engine with init or next commands, and reads back the 160-bit digest one word at a time.

The message block is held in registers that belong to this block, not to the engine. The host can therefore write the following block while the engine is still working on the current one. The engine is outside this block. It takes the flat block and the command pulses, and it returns its ready flag, its digest-valid flag and the digest. Read data is combinational from the address. Every register clears through an asynchronous active-high reset.

Top module: `sha1_host_regs`

## Requirements
- R1: While reset is asserted and after it is released, the block words are all zero, core_block is zero, core_init and core_next are low, and rdata is zero when no read is in progress.
- R2: A read (cs=1, we=0) of address 0x00 returns 0x53484131. Address 0x01 returns 0x20202020, and address 0x02 returns 0x302E3530.
- R3: A write to address 0x08 with wdata bit 0 set drives core_init high for exactly the one cycle that follows the write edge. Wdata bit 1 does the same for core_next. Both bits can be set in the same write.
- R4: Neither command pin rises without a write to 0x08 that has the matching bit set. A write to 0x08 with both bits clear produces no pulse.
- R5: A read of address 0x09 returns core_ready in bit 0 and core_digest_valid in bit 1, with bits 31:2 zero.
- R6: A write to address 0x10+i (i = 0..15) stores wdata as block word i, and a read of that address returns the stored word.
- R7: Block word i appears on core_block[511-32*i -: 32]. Word 0 at 0x10 is the most significant word, and the new value is visible in the cycle after the write edge.
- R8: A read of address 0x20+j (j = 0..4) returns core_digest[159-32*j -: 32], so 0x20 holds the most significant digest word.
- R9: Block writes take effect whatever the state of core_ready, including while the engine reports busy.
- R10: Reads of any address not listed in R2, R5, R6 or R8 (including 0x08) return zero. Writes to any address other than 0x08 and 0x10..0x1F change no register.
- R11: rdata is zero whenever cs is low or we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs | input | 1 | Chip select for a host access |
| we | input | 1 | Write enable, 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| core_init | output | 1 | One-cycle start pulse for a new message |
| core_next | output | 1 | One-cycle pulse to hash the next block |
| core_block | output | 512 | Message block, word 0 in the top bits |
| core_ready | input | 1 | Engine idle flag |
| core_digest | input | 160 | Digest from the engine |
| core_digest_valid | input | 1 | Digest valid flag from the engine |

## Verification
Directed sequences cover the following:
- walking writes over all sixteen block words, which show whether the address-to-slice mapping is reversed or shifted;
- all four ready/valid combinations, which show whether the status bits are swapped;
- control writes with value 0, 1, 2 and 3, which separate the init pulse from the next pulse and show whether a pulse stays high for longer than one cycle.

A long run of seeded random writes and reads over the whole 0x00–0x3F range, with random data, checks the model of the block words against both rdata and core_block after every access. This run exposes writes that leak into identification, digest or unmapped addresses. Block writes are also made with core_ready low, to show that the busy state does not gate them.

// File: rtl/sha1_regmap_pkg.sv
package sha1_regmap_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_ID0  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ID1  = 8'h01;
    localparam logic [ADDR_W-1:0] A_VER  = 8'h02;
    localparam logic [ADDR_W-1:0] A_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h09;
    localparam logic [ADDR_W-1:0] A_BLK  = 8'h10;
    localparam logic [ADDR_W-1:0] A_DIG  = 8'h20;

    localparam logic [WORD_W-1:0] ID_WORD0 = 32'h5348_4131;
    localparam logic [WORD_W-1:0] ID_WORD1 = 32'h2020_2020;
    localparam logic [WORD_W-1:0] VER_WORD = 32'h302E_3530;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } host_req_t;

    typedef struct packed {
        logic init;
        logic next;
    } cmd_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

endpackage

// File: rtl/sha1_cmd_pulse.sv
module sha1_cmd_pulse
    import sha1_regmap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req,
    output cmd_t      cmd
);
    logic ctrl_wr;
    assign ctrl_wr = req.sel && req.wr && (req.addr == A_CTRL);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cmd <= '0;
        end else begin
            cmd.init <= ctrl_wr && req.data[0];
            cmd.next <= ctrl_wr && req.data[1];
        end
    end

    // R3
    init_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && req.data[0] |=> cmd.init);
    // R3
    next_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && req.data[1] |=> cmd.next);
endmodule

// File: rtl/sha1_block_bank.sv
module sha1_block_bank
    import sha1_regmap_pkg::*;
#(
    parameter int NW = 16,
    parameter int W  = WORD_W,
    parameter logic [ADDR_W-1:0] BASE = A_BLK
) (
    input  logic          clk,
    input  logic          rst,
    input  host_req_t     req,
    output logic [NW*W-1:0] block
);
    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam logic [ADDR_W-1:0] MY_ADDR = BASE + ADDR_W'(i);
        logic hit;
        assign hit = req.sel && req.wr && (req.addr == MY_ADDR);
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                block[(NW-i)*W-1 -: W] <= '0;
            end else if (hit) begin
                block[(NW-i)*W-1 -: W] <= req.data[W-1:0];
            end
        end
    end
endmodule

// File: rtl/sha1_read_mux.sv
module sha1_read_mux
    import sha1_regmap_pkg::*;
#(
    parameter int NW = 16,
    parameter int ND = 5,
    parameter int W  = WORD_W
) (
    input  host_req_t       req,
    input  logic [NW*W-1:0] block,
    input  logic [ND*W-1:0] digest,
    input  logic            ready,
    input  logic            dvalid,
    output logic [W-1:0]    rdata
);
    localparam int BI_W = $clog2(NW);
    localparam int DI_W = (ND > 1) ? $clog2(ND) : 1;

    logic [ADDR_W-1:0] boff, doff;
    logic [BI_W-1:0]   bidx;
    logic [DI_W-1:0]   didx;

    assign boff = req.addr - A_BLK;
    assign doff = req.addr - A_DIG;
    assign bidx = boff[BI_W-1:0];
    assign didx = doff[DI_W-1:0];

    always_comb begin
        rdata = '0;
        if (req.sel && !req.wr) begin
            if (req.addr == A_ID0)                 rdata = ID_WORD0[W-1:0];
            else if (req.addr == A_ID1)            rdata = ID_WORD1[W-1:0];
            else if (req.addr == A_VER)            rdata = VER_WORD[W-1:0];
            else if (req.addr == A_STAT)           rdata = {{(W-2){1'b0}}, dvalid, ready};
            else if (in_window(req.addr, A_BLK, NW)) rdata = block[(NW-1-int'(bidx))*W +: W];
            else if (in_window(req.addr, A_DIG, ND)) rdata = digest[(ND-1-int'(didx))*W +: W];
        end
    end
endmodule

// File: rtl/sha1_host_regs.sv
module sha1_host_regs
    import sha1_regmap_pkg::*;
#(
    parameter int NW = 16,
    parameter int ND = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    output logic                 core_init,
    output logic                 core_next,
    output logic [NW*WORD_W-1:0] core_block,
    input  logic                 core_ready,
    input  logic [ND*WORD_W-1:0] core_digest,
    input  logic                 core_digest_valid
);
    host_req_t req;
    cmd_t      cmd;

    assign req = '{sel: cs, wr: we, addr: addr, data: wdata};

    sha1_cmd_pulse u_cmd (
        .clk (clk),
        .rst (rst),
        .req (req),
        .cmd (cmd)
    );

    sha1_block_bank #(.NW(NW), .W(WORD_W), .BASE(A_BLK)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .block (core_block)
    );

    sha1_read_mux #(.NW(NW), .ND(ND), .W(WORD_W)) u_rmux (
        .req    (req),
        .block  (core_block),
        .digest (core_digest),
        .ready  (core_ready),
        .dvalid (core_digest_valid),
        .rdata  (rdata)
    );

    assign core_init = cmd.init;
    assign core_next = cmd.next;

    logic live_q;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R4
    no_stray_init_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && core_init |-> $past(cs && we && addr == A_CTRL && wdata[0]));
    // R4
    no_stray_next_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && core_next |-> $past(cs && we && addr == A_CTRL && wdata[1]));
    // R7
    top_word_load_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(cs && we && addr == A_BLK)
        |-> core_block[NW*WORD_W-1 -: WORD_W] == $past(wdata));
    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs || we) |-> rdata == '0);
    // R5
    status_read_chk: assert property (@(posedge clk) disable iff (rst)
        cs && !we && addr == A_STAT |-> rdata[1:0] == {core_digest_valid, core_ready});
endmodule

// File: tb/sha1_host_regs_bench.sv
module sha1_host_regs_bench;
    localparam int NW = 16;
    localparam int ND = 5;

    logic         clk = 1'b0;
    logic         rst;
    logic         cs, we;
    logic [7:0]   addr;
    logic [31:0]  wdata;
    logic [31:0]  rdata;
    logic         core_init, core_next;
    logic [511:0] core_block;
    logic         core_ready;
    logic [159:0] core_digest;
    logic         core_digest_valid;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [31:0] model [NW];

    always #2 clk = ~clk;

    sha1_host_regs u_sha1_host_regs (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .core_init(core_init), .core_next(core_next),
        .core_block(core_block), .core_ready(core_ready),
        .core_digest(core_digest), .core_digest_valid(core_digest_valid)
    );

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] model_block();
        logic [511:0] b;
        for (int i = 0; i < NW; i++) b[511-32*i -: 32] = model[i];
        return b;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return 32'h5348_4131;
        if (a == 8'h01) return 32'h2020_2020;
        if (a == 8'h02) return 32'h302E_3530;
        if (a == 8'h09) return {30'd0, core_digest_valid, core_ready};
        if (a >= 8'h10 && a < 8'h20) return model[a - 8'h10];
        if (a >= 8'h20 && a < 8'h25) return core_digest[159 - 32*(a - 8'h20) -: 32];
        return 32'd0;
    endfunction

    // Drive a write at a falling edge; returns at the falling edge after the capture edge.
    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        if (a >= 8'h10 && a < 8'h20) model[a - 8'h10] = d;
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        #1;
        check(req, {480'd0, rdata}, {480'd0, exp_read(a)});
        cs = 1'b0;
    endtask

    task automatic ctrl_case(input logic [1:0] v);
        do_write(8'h08, {30'd0, v});
        check("R3 pulse cycle", {510'd0, core_init, core_next}, {510'd0, v[0], v[1]});
        @(negedge clk);
        check("R4 pulse ends", {510'd0, core_init, core_next}, 512'd0);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd2024);
        rst = 1'b1; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        core_ready = 1'b1; core_digest = '0; core_digest_valid = 1'b0;
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 block in reset", core_block, 512'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cmds after reset", {510'd0, core_init, core_next}, 512'd0);
        check("R1 rdata idle", {480'd0, rdata}, 512'd0);
        check("R1 block after reset", core_block, 512'd0);

        do_read(8'h00, "R2 id0");
        do_read(8'h01, "R2 id1");
        do_read(8'h02, "R2 version");

        ctrl_case(2'b01);
        ctrl_case(2'b10);
        ctrl_case(2'b11);
        ctrl_case(2'b00);
        do_read(8'h08, "R10 ctrl reads zero");

        for (int s = 0; s < 4; s++) begin
            core_ready = s[0]; core_digest_valid = s[1];
            do_read(8'h09, "R5 status");
        end
        core_ready = 1'b1;

        core_digest = {32'hA1A1_0001, 32'hB2B2_0002, 32'hC3C3_0003, 32'hD4D4_0004, 32'hE5E5_0005};
        core_digest_valid = 1'b1;
        for (int j = 0; j < ND; j++) do_read(8'h20 + 8'(j), "R8 digest word");

        for (int i = 0; i < NW; i++) begin
            do_write(8'h10 + 8'(i), 32'h0100_0000 * (i + 1) + 32'(i));
            check("R7 block mapping", core_block, model_block());
        end
        for (int i = 0; i < NW; i++) do_read(8'h10 + 8'(i), "R6 block readback");

        core_ready = 1'b0;
        do_write(8'h15, 32'hDEAD_BEEF);
        check("R9 write while busy", core_block, model_block());
        do_write(8'h10, 32'hCAFE_F00D);
        check("R9 top word while busy", core_block, model_block());
        core_ready = 1'b1;

        do_write(8'h00, 32'hFFFF_FFFF);
        do_write(8'h02, 32'h1234_5678);
        do_write(8'h09, 32'hFFFF_FFFF);
        do_write(8'h20, 32'h0BAD_0BAD);
        do_write(8'h3F, 32'h5555_AAAA);
        check("R10 ignored writes keep block", core_block, model_block());
        do_read(8'h00, "R10 id0 after write");
        do_read(8'h02, "R10 version after write");
        do_read(8'h20, "R10 digest after write");
        do_read(8'h05, "R10 unmapped read");
        do_read(8'h25, "R10 unmapped read");
        do_read(8'hFF, "R10 unmapped read");

        @(negedge clk);
        cs = 1'b0; we = 1'b0; addr = 8'h00; #1;
        check("R11 cs low", {480'd0, rdata}, 512'd0);
        cs = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'h0; #1;
        check("R11 write cycle", {480'd0, rdata}, 512'd0);
        @(negedge clk);
        cs = 1'b0; we = 1'b0;

        for (int n = 0; n < 400; n++) begin
            logic [7:0]  ra;
            logic [31:0] rd;
            ra = 8'($urandom % 64);
            rd = $urandom;
            core_ready = 1'($urandom);
            if ($urandom % 2 == 0) begin
                do_write(ra, rd);
                check("R6 random write", core_block, model_block());
                check("R3 random pulse", {510'd0, core_init, core_next},
                      {510'd0, (ra == 8'h08) && rd[0], (ra == 8'h08) && rd[1]});
            end else begin
                do_read(ra, "R10 random read");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule